// File: doc/BRIEF.md
# Bidirectional Scan-Token Shift Register

This block is the logic core of a row or gate scan driver for a matrix display. A one-bit token is taken from a start-pulse pin on every rising clock edge. The bits already held move one stage along a 480-stage chain on the same edge. Each stage drives one output bit, where 1 stands for the positive rail and 0 for the negative rail. When the token reaches the far end of the chain, a cascade pulse is sent, half a clock late, to the start pin of the next chip.

Static configuration inputs set three things: the shift direction, a shortened 400-stage chain, and which 400-stage window of the outputs the shortened chain uses. Two start-pulse pins swap between the input role and the cascade-output role according to direction. Each pin is presented as a separate input, output and output-enable. Two controls act on every output: a global blank that overrides the register contents at once, and a polarity control that sets the data sense. The configuration inputs `dir`, `len_short`, `justify` and `pol` are expected to stay fixed while a scan is running.

Top module: `scan_token_shifter`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0 and brings both cascade outputs low; after reset, with blank low, every `drv` bit equals `pol`.
- R2: With `dir`=0, `sp_a_in` is sampled on each rising edge into the lowest-indexed active stage, and every active stage takes the value of the stage one index below it on the same edge.
- R3: With `dir`=1, `sp_b_in` is sampled into the highest-indexed active stage, and every active stage takes the value of the stage one index above it.
- R4: With `len_short`=0, all 480 stages form the chain (indices 0..479, where `drv[0]` is the first output). With `len_short`=1, the chain is 400 stages long.
- R5: With `len_short`=1, `justify`=0 uses stages 0..399 and `justify`=1 uses stages 80..479. With `len_short`=0, `justify` has no effect.
- R6: Stages outside the active window hold 0, so their outputs show the level of a zero data bit.
- R7: The cascade output goes high on the falling edge that follows the rising edge which loads a 1 into the last active stage, and goes low on the next falling edge. In general it follows the last active stage, half a clock late. The last active stage is the highest index for `dir`=0 and the lowest index for `dir`=1.
- R8: `sp_b_oe`=1 and `sp_a_oe`=0 when `dir`=0; the reverse holds when `dir`=1. The cascade pulse appears only on the enabled pin's output, the other output stays 0, and the input of the enabled pin has no effect.
- R9: With `blank`=0, `drv[i]` is 1 exactly when the stage bit differs from `pol`: with `pol`=1 a 0 bit gives the positive rail, and with `pol`=0 a 1 bit gives it.
- R10: With `blank`=1, every `drv` bit equals `pol` in the same cycle, and the chain keeps shifting underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages load on the rising edge, the cascade on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | Shift direction: 0 = up from pin A, 1 = down from pin B |
| len_short | input | 1 | 0 = 480-stage chain, 1 = 400-stage chain |
| justify | input | 1 | Window for the short chain: 0 = low 400, 1 = high 400 |
| blank | input | 1 | Forces every output to `pol` |
| pol | input | 1 | Output polarity |
| sp_a_in | input | 1 | Start-pulse pin A, input side |
| sp_a_out | output | 1 | Start-pulse pin A, cascade output side |
| sp_a_oe | output | 1 | Pin A output enable |
| sp_b_in | input | 1 | Start-pulse pin B, input side |
| sp_b_out | output | 1 | Start-pulse pin B, cascade output side |
| sp_b_oe | output | 1 | Pin B output enable |
| drv | output | 480 | One output level per stage, 1 = positive rail |

## Verification
A single token is walked through all eight direction, length and window combinations. Each one has a random fixed polarity, and blank pulses are scattered through the scan. These runs tell apart window offsets, scan order and the rising-edge count at which the cascade fires. Random bit streams under random configurations fill the chain with dense patterns. They expose neighbour mix-ups and data leaking into or out of the trimmed stages, and they compare the cascade pin against the last active stage half a cycle later. Throughout, the input of the pin that is currently driving is toggled at random to show that it has no effect.

// File: rtl/scan_token_shifter.sv
module scan_token_shifter #(
  parameter int N     = 480,
  parameter int SHORT = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir,
  input  logic         len_short,
  input  logic         justify,
  input  logic         blank,
  input  logic         pol,
  input  logic         sp_a_in,
  output logic         sp_a_out,
  output logic         sp_a_oe,
  input  logic         sp_b_in,
  output logic         sp_b_out,
  output logic         sp_b_oe,
  output logic [N-1:0] drv
);
  localparam int W    = $clog2(N);
  localparam int TRIM = N - SHORT;

  logic [N-1:0] stg, nxt;
  logic [W-1:0] lo, hi;
  logic         last, casc;

  assign lo = (len_short && justify)  ? W'(TRIM)      : '0;
  assign hi = (len_short && !justify) ? W'(SHORT - 1) : W'(N - 1);

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic act, up_src, dn_src;
    assign act = (W'(i) >= lo) && (W'(i) <= hi);
    if (i == 0) begin : g_first
      assign up_src = sp_a_in;
    end else begin : g_up
      assign up_src = (W'(i) == lo) ? sp_a_in : stg[i-1];
    end
    if (i == N - 1) begin : g_last
      assign dn_src = sp_b_in;
    end else begin : g_dn
      assign dn_src = (W'(i) == hi) ? sp_b_in : stg[i+1];
    end
    assign nxt[i] = act & (dir ? dn_src : up_src);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= nxt;
  end

  assign last = dir ? stg[lo] : stg[hi];

  always_ff @(negedge clk) begin
    if (!rst_n) casc <= 1'b0;
    else        casc <= last;
  end

  assign sp_a_oe  = dir;
  assign sp_b_oe  = ~dir;
  assign sp_a_out = dir & casc;
  assign sp_b_out = ~dir & casc;
  assign drv      = blank ? {N{pol}} : (stg ^ {N{pol}});
endmodule

module scan_token_shifter_chk #(
  parameter int N     = 480,
  parameter int SHORT = 400
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir,
  input logic         len_short,
  input logic         justify,
  input logic         blank,
  input logic         pol,
  input logic         sp_a_in,
  input logic         sp_b_in,
  input logic         sp_a_oe,
  input logic         sp_b_oe,
  input logic         sp_a_out,
  input logic         sp_b_out,
  input logic [N-1:0] stg,
  input logic [N-1:0] drv
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (stg == '0));

  a_r2_up_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && !len_short) |=> (stg[N-1:1] == $past(stg[N-2:0]) && stg[0] == $past(sp_a_in)));

  a_r3_down_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !len_short) |=> (stg[N-2:0] == $past(stg[N-1:1]) && stg[N-1] == $past(sp_b_in)));

  a_r6_trim_top: assert property (@(posedge clk) disable iff (!rst_n)
    (len_short && !justify) |=> (stg[N-1:SHORT] == '0));

  a_r6_trim_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (len_short && justify) |=> (stg[N-SHORT-1:0] == '0));

  a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_a_oe != sp_b_oe) && !(sp_a_out && sp_b_out) && (sp_a_oe == dir));

  a_r10_blank_override: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (drv == {N{pol}}));
endmodule

bind scan_token_shifter scan_token_shifter_chk #(.N(N), .SHORT(SHORT)) u_chk (.*);

// File: tb/tb_scan_token_shifter.sv
`timescale 1ns/1ps
module tb_scan_token_shifter;
  localparam int N = 480, SHORT = 400;

  logic clk = 0, rst_n = 0, dir = 0, len_short = 0, justify = 0, blank = 0, pol = 1;
  logic sp_a_in = 0, sp_b_in = 0;
  logic sp_a_out, sp_a_oe, sp_b_out, sp_b_oe;
  logic [N-1:0] drv;
  int errors = 0, checks = 0;

  scan_token_shifter #(.N(N), .SHORT(SHORT)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk_vec(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%b exp=%b", req, got, exp);
    end
  endtask

  function automatic logic [N-1:0] out_of(logic [N-1:0] bits, bit blk, bit p);
    return blk ? {N{p}} : (bits ^ {N{p}});
  endfunction

  function automatic int lo_of(bit ls, bit j);
    return (ls && j) ? N - SHORT : 0;
  endfunction

  function automatic int hi_of(bit ls, bit j);
    return (ls && !j) ? SHORT - 1 : N - 1;
  endfunction

  task automatic do_reset();
    rst_n = 0; sp_a_in = 0; sp_b_in = 0; blank = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_vec("R1 reset outputs", drv, {N{pol}});
    @(negedge clk); #1;
    chk_bit("R1 reset cascade A", sp_a_out, 1'b0);
    chk_bit("R1 reset cascade B", sp_b_out, 1'b0);
    rst_n = 1;
  endtask

  task automatic token_scan(bit d, bit ls, bit j, bit p);
    int lo, hi, len, pos;
    logic [N-1:0] bits;
    dir = d; len_short = ls; justify = j; pol = p;
    do_reset();
    lo = lo_of(ls, j); hi = hi_of(ls, j); len = hi - lo + 1;
    chk_bit("R8 pin A enable", sp_a_oe, d);
    chk_bit("R8 pin B enable", sp_b_oe, !d);
    if (d) sp_b_in = 1; else sp_a_in = 1;
    for (int k = 1; k <= len + 2; k++) begin
      @(posedge clk); #1;
      pos = (k <= len) ? (d ? hi - (k - 1) : lo + (k - 1)) : -1;
      bits = '0;
      if (pos >= 0) bits[pos] = 1'b1;
      if (d) chk_vec("R3 R4 R5 R6 R9 R10 token path", drv, out_of(bits, blank, pol));
      else   chk_vec("R2 R4 R5 R6 R9 R10 token path", drv, out_of(bits, blank, pol));
      @(negedge clk); #1;
      chk_bit("R7 R8 cascade pulse", d ? sp_a_out : sp_b_out, k == len);
      chk_bit("R8 idle pin output", d ? sp_b_out : sp_a_out, 1'b0);
      if (d) begin sp_b_in = 0; sp_a_in = 1'($urandom % 2); end
      else   begin sp_a_in = 0; sp_b_in = 1'($urandom % 2); end
      blank = ($urandom % 8) == 0;
    end
    blank = 0;
  endtask

  task automatic stream_run(bit d, bit ls, bit j, bit p, int cycles);
    int lo, hi;
    logic [N-1:0] m;
    logic b;
    dir = d; len_short = ls; justify = j; pol = p;
    do_reset();
    lo = lo_of(ls, j); hi = hi_of(ls, j);
    m = '0;
    for (int c = 0; c < cycles; c++) begin
      b = 1'($urandom % 2);
      if (d) begin sp_b_in = b; sp_a_in = 1'($urandom % 2); end
      else   begin sp_a_in = b; sp_b_in = 1'($urandom % 2); end
      blank = ($urandom % 16) == 0;
      @(posedge clk); #1;
      if (d) begin
        for (int i = lo; i < hi; i++) m[i] = m[i+1];
        m[hi] = b;
      end else begin
        for (int i = hi; i > lo; i--) m[i] = m[i-1];
        m[lo] = b;
      end
      chk_vec(d ? "R3 R5 R6 R10 stream" : "R2 R4 R6 R9 stream", drv, out_of(m, blank, pol));
      @(negedge clk); #1;
      chk_bit("R7 cascade follows last stage", d ? sp_a_out : sp_b_out, d ? m[lo] : m[hi]);
    end
    blank = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int cfg = 0; cfg < 8; cfg++)
      token_scan(cfg[0], cfg[2], cfg[1], 1'($urandom % 2));
    stream_run(0, 0, 1, 1, 600);
    stream_run(1, 0, 0, 0, 600);
    stream_run(1, 1, 1, 1, 500);
    stream_run(0, 1, 0, 0, 500);
    stream_run(0, 1, 1, 1'($urandom % 2), 500);
    stream_run(1, 1, 0, 1'($urandom % 2), 500);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule